// File: doc/BRIEF.md
# Mode-Configurable Event Time-Tag Counter

This block keeps a running tag value and stamps it onto every detector event. A three-bit mode code picks what the tag means. It can be switched off, it can run as a timer that advances on every system clock cycle, or it can count rising edges of an asynchronous external tag line. Some of the codes are meant for use while the state input is active. In those codes the external line can also act as a clear for the timer instead of a count source.

A small state machine registers the mode code together with the state-input enable. The machine holds one of five behaviour states: `ST_OFF`, `ST_TIMER`, `ST_COUNT`, `ST_TIMER_XCLR` and `ST_BADMODE`. On every clock it moves to the state that the present inputs select, so any state can reach any other. The transitions are named as follows:
- *to_off*: mode 0, 3 or 4, any enable.
- *to_timer*: mode 1 with the enable low.
- *to_count*: mode 2 with the enable low, or mode 6.
- *to_timer_xclr*: mode 5.
- *to_bad*: mode 7, or mode 1 or 2 with the enable high.

On an event strobe the current tag is latched into an output register, either at full width or cut down to a narrow field for the short event word.

Top module: `event_tag_counter`

## Requirements
- R1: In modes 0, 3 and 4 the counter is held at zero and external tag pulses have no effect. An event then captures 0.
- R2: In mode 1 with `state_en_i` low, the counter advances by one on every clock. A high `meas_start_i` loads zero instead.
- R3: In mode 2 with `state_en_i` low, and in mode 6, each rising edge of `tag_pulse_i` advances the counter once. The edge passes through a two-flop synchronizer and an edge detector, so the counter reflects an edge sampled at clock k after clock k+2. A high `meas_start_i` loads zero.
- R4: In mode 5 the counter advances on every clock. A synchronized rising edge of `tag_pulse_i`, or `meas_start_i`, loads zero.
- R5: When a clear and an increment apply in the same cycle, the counter loads zero.
- R6: The counter wraps modulo 2^TAG_W.
- R7: Mode 7, and modes 1 or 2 with `state_en_i` high, act as tagging off. In that case `mode_err_o` is high from the clock after the code is sampled.
- R8: When `event_i` is high at a clock edge, `tag_o` takes the counter value held just before that edge, and `tag_valid_o` is high for that one cycle only. Otherwise `tag_o` keeps its value.
- R9: With `wide_fmt_i` = 1 (8-byte word), the full counter is output. With 0 (4-byte word), only the low NARROW_W bits are output, with the upper bits zero.
- R10: While `rst_ni` is low, all outputs are zero and the behaviour state is `ST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Tag mode code 0..7 |
| tag_pulse_i | input | 1 | Asynchronous external tag line |
| meas_start_i | input | 1 | Start-of-measurement strobe |
| state_en_i | input | 1 | State input in use |
| event_i | input | 1 | Detector event strobe |
| wide_fmt_i | input | 1 | 1 = 8-byte word, 0 = 4-byte word |
| tag_o | output | TAG_W | Latched tag |
| tag_valid_o | output | 1 | Tag latched this cycle |
| mode_err_o | output | 1 | Illegal mode combination |

## Verification
The bench builds the block with TAG_W = 12 and NARROW_W = 8. With these widths the timer wraps after 4096 cycles, which puts R6 in reach of a short run. The 4-bit gap between the narrow field and the full tag is also large enough to show any leak of upper bits in the 4-byte format. Random mode, enable, pulse and event traffic covers every code combination. Directed runs place a synchronized edge and a measurement start in the same cycle.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_TIMER      = 3'd1,
        ST_COUNT      = 3'd2,
        ST_TIMER_XCLR = 3'd3,
        ST_BADMODE    = 3'd4
    } tag_state_e;
endpackage

// File: rtl/tag_pulse_sync.sv
module tag_pulse_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise_o = s2_q & ~s3_q;

    AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o); // R3
endmodule

// File: rtl/tag_mode_fsm.sv
module tag_mode_fsm
    import tag_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              state_en_i,
    output tag_state_e        state_o,
    output logic              err_o
);
    tag_state_e state_q, state_d;

    // next-state selection from the mode code
    always_comb begin
        state_d = ST_OFF;
        unique case (mode_i)
            3'd0, 3'd3, 3'd4: state_d = ST_OFF;
            3'd1:             state_d = state_en_i ? ST_BADMODE : ST_TIMER;
            3'd2:             state_d = state_en_i ? ST_BADMODE : ST_COUNT;
            3'd5:             state_d = ST_TIMER_XCLR;
            3'd6:             state_d = ST_COUNT;
            default:          state_d = ST_BADMODE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // outputs from the state
    always_comb begin
        err_o = 1'b0;
        unique case (state_q)
            ST_BADMODE: err_o = 1'b1;
            default:    err_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'd7) |=> err_o); // R7
    AST_STATE_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_en_i && (mode_i == 3'd1 || mode_i == 3'd2)) |=> err_o); // R7
endmodule

// File: rtl/tag_counter.sv
module tag_counter
    import tag_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tag_state_e       state_i,
    input  logic             rise_i,
    input  logic             meas_start_i,
    output logic [TAG_W-1:0] cnt_o
);
    logic [TAG_W-1:0] cnt_q, cnt_d;
    logic inc, clr;

    always_comb begin
        inc = 1'b0;
        clr = 1'b0;
        unique case (state_i)
            ST_OFF, ST_BADMODE: clr = 1'b1;
            ST_TIMER:      begin inc = 1'b1;   clr = meas_start_i;          end
            ST_COUNT:      begin inc = rise_i; clr = meas_start_i;          end
            ST_TIMER_XCLR: begin inc = 1'b1;   clr = meas_start_i | rise_i; end
            default:       clr = 1'b1;
        endcase
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
        else          cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_OFF || state_i == ST_BADMODE) |=> (cnt_q == '0)); // R1
    AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_TIMER && !meas_start_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_COUNT && rise_i && meas_start_i) |=> (cnt_q == '0)); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_COUNT && !rise_i && !meas_start_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/tag_event_latch.sv
module tag_event_latch #(
    parameter int TAG_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             event_i,
    input  logic             wide_fmt_i,
    input  logic [TAG_W-1:0] cnt_i,
    output logic [TAG_W-1:0] tag_o,
    output logic             valid_o
);
    localparam int UPPER_W = TAG_W - NARROW_W;

    logic [TAG_W-1:0] shaped;

    generate
        if (UPPER_W > 0) begin : g_split
            assign shaped = wide_fmt_i ? cnt_i : {{UPPER_W{1'b0}}, cnt_i[NARROW_W-1:0]};
        end else begin : g_flat
            assign shaped = cnt_i;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tag_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= event_i;
            if (event_i) tag_o <= shaped;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i |=> valid_o); // R8
    AST_HOLD_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !event_i |=> $stable(tag_o)); // R8
    AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i && !wide_fmt_i) |=> ((tag_o >> NARROW_W) == '0)); // R9
endmodule

// File: rtl/event_tag_counter.sv
module event_tag_counter
    import tag_pkg::*;
#(
    parameter int TAG_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              tag_pulse_i,
    input  logic              meas_start_i,
    input  logic              state_en_i,
    input  logic              event_i,
    input  logic              wide_fmt_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic              tag_valid_o,
    output logic              mode_err_o
);
    tag_state_e       state;
    logic             rise;
    logic [TAG_W-1:0] cnt;

    tag_pulse_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (tag_pulse_i),
        .rise_o  (rise)
    );

    tag_mode_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_i),
        .state_en_i (state_en_i),
        .state_o    (state),
        .err_o      (mode_err_o)
    );

    tag_counter #(.TAG_W(TAG_W)) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_i      (state),
        .rise_i       (rise),
        .meas_start_i (meas_start_i),
        .cnt_o        (cnt)
    );

    tag_event_latch #(.TAG_W(TAG_W), .NARROW_W(NARROW_W)) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .event_i    (event_i),
        .wide_fmt_i (wide_fmt_i),
        .cnt_i      (cnt),
        .tag_o      (tag_o),
        .valid_o    (tag_valid_o)
    );

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        !rst_ni |-> (tag_o == '0 && !tag_valid_o && !mode_err_o)); // R10
endmodule

// File: tb/tb_event_tag_counter.sv
module tb_event_tag_counter;
    localparam int TW = 12;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic pulse = 1'b0, mstart = 1'b0, sen = 1'b0, ev = 1'b0, wide = 1'b1;
    logic [TW-1:0] tag;
    logic valid, err;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    string dir_tag = "";

    always #2 clk = ~clk;

    event_tag_counter #(.TAG_W(TW), .NARROW_W(NW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tag_pulse_i(pulse),
        .meas_start_i(mstart), .state_en_i(sen), .event_i(ev),
        .wide_fmt_i(wide), .tag_o(tag), .tag_valid_o(valid), .mode_err_o(err));

    // behaviour codes of the model: 0 off, 1 timer, 2 count, 3 timer+ext clear, 4 bad
    function automatic int beh_of(logic [2:0] m, logic s);
        case (m)
            3'd0, 3'd3, 3'd4: return 0;
            3'd1: return s ? 4 : 1;
            3'd2: return s ? 4 : 2;
            3'd5: return 3;
            3'd6: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [TW-1:0] next_cnt(int b, logic [TW-1:0] c, logic r, logic ms);
        case (b)
            1: return ms ? '0 : c + 1'b1;
            2: return ms ? '0 : (r ? c + 1'b1 : c);
            3: return (ms || r) ? '0 : c + 1'b1;
            default: return '0;
        endcase
    endfunction

    function automatic string lbl_of(int b);
        case (b)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R7";
            default: return "R1";
        endcase
    endfunction

    logic m1, m2, m3;
    int m_beh;
    logic [TW-1:0] m_cnt, m_tag;
    logic m_valid;
    string m_lbl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 <= 0; m2 <= 0; m3 <= 0; m_beh <= 0; m_cnt <= '0;
            m_tag <= '0; m_valid <= 0; m_lbl <= "R10";
        end else begin
            m1 <= pulse; m2 <= m1; m3 <= m2;
            m_beh <= beh_of(mode, sen);
            m_cnt <= next_cnt(m_beh, m_cnt, m2 & ~m3, mstart);
            m_valid <= ev;
            if (ev) begin
                m_tag <= wide ? m_cnt : {{(TW-NW){1'b0}}, m_cnt[NW-1:0]};
                m_lbl <= (dir_tag != "") ? dir_tag : lbl_of(m_beh);
            end
        end
    end

    task automatic chk(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_lbl, tag, m_tag);
            chk("R8", TW'(valid), TW'(m_valid));
            chk("R7", TW'(err), TW'(m_beh == 4));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        chk("R10", tag, '0);
        chk("R10", TW'(valid), '0);
        chk("R10", TW'(err), '0);
        rst_n = 1'b1;
        step(2);

        // R1: off modes ignore pulses
        dir_tag = "R1";
        foreach (mode[i]) begin end
        for (int k = 0; k < 30; k++) begin
            mode = (k < 10) ? 3'd0 : ((k < 20) ? 3'd3 : 3'd4);
            sen = k[0]; pulse = k[1]; ev = (k % 3 == 0);
            step(1);
        end
        ev = 0;

        // R7: bad code and conflicts
        dir_tag = "R7";
        mode = 3'd7; step(3);
        mode = 3'd1; sen = 1; step(3);
        mode = 3'd2; step(3); sen = 0;

        // R6: timer wrap
        dir_tag = "R6";
        mode = 3'd1; wide = 1; pulse = 0;
        step((1 << TW) + 5);
        ev = 1; step(3); ev = 0;

        // R5: synchronized edge and measurement start in the same cycle
        dir_tag = "R5";
        mode = 3'd2; step(3);
        for (int k = 0; k < 4; k++) begin
            pulse = 1; step(2);
            mstart = 1; step(1); mstart = 0;
            ev = 1; step(1); ev = 0;
            pulse = 0; step(3);
        end

        // R4: mode 5 clear by external edge
        dir_tag = "R4";
        mode = 3'd5; sen = 1; step(20);
        pulse = 1; step(4); ev = 1; step(2); ev = 0; pulse = 0; step(3);

        // R9: narrow format under timer
        dir_tag = "R9";
        mode = 3'd1; sen = 0; wide = 0;
        for (int k = 0; k < 40; k++) begin
            ev = (k % 5 == 0); step(13);
        end
        ev = 0;

        // random mix
        dir_tag = "";
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 40) == 0) mode = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 60) == 0) sen = ~sen;
            if ($urandom_range(0, 3) == 0) pulse = ~pulse;
            mstart = ($urandom_range(0, 150) == 0);
            ev = ($urandom_range(0, 3) == 0);
            wide = ($urandom_range(0, 5) != 0);
            step(1);
        end
        ev = 0; mstart = 0;
        step(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule